// File: doc/BRIEF.md
# Flash Command Sequencer

This block turns command sequences on a flash memory's write bus into one-cycle operation requests for a sixteen-block array model. Each bus write cycle appears as a one-clock `wr_en` pulse carrying an address and a command or data byte. The sequencer remembers which cycle of a command it is in and checks that two-cycle commands end with the confirm byte D0h. It latches block indices, word or byte counts, write addresses and write data. It holds one lock bit per block, and it refuses modifying requests on locked blocks while write protection is active.

The outputs are single-clock strobes with their operands, a register for the ready/busy output mode, a deep power-down flag and two sticky error flags. An array controller acts on the strobes. Page-buffer contents, programming timing and supply selection are handled elsewhere.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), all strobes are low, `seq_err`, `prot_err` and `deep_pd` are 0, `rb_mode` is 0 (level), and every lock bit is clear.
- R2: A write of 20h followed by a write of D0h raises `erase_stb`, with `op_block` equal to the top four address bits (`bus_addr[19:16]`) of the D0h cycle.
- R3: A write of 77h followed by D0h raises `lock_stb` with `op_block` taken from the D0h cycle, and sets that block's lock bit. Lock bits stay set until reset.
- R4: While `wp_n` is low, an erase (20h), a page-buffer write (0Ch) or a two-byte write (FBh) aimed at a locked block gives no strobe and sets `prot_err`. While `wp_n` is high, the same requests are accepted.
- R5: A7h+D0h raises `erase_all_stb`, with bit i of `op_mask` set for each block i that may be erased: every block that is not locked when `wp_n` is low, and all blocks when `wp_n` is high. 97h+D0h and 99h+D0h raise `upload_stb`, with `op_info` = 0 for 97h and 1 for 99h.
- R6: If a two-cycle command gets a second byte other than D0h, `seq_err` is set, no strobe is issued and the sequencer returns to idle. Writing 50h from idle clears both `seq_err` and `prot_err`.
- R7: 96h followed by 01h, 02h, 03h or 04h sets `rb_mode` to 0 (level), 1 (pulse on write), 2 (pulse on erase) or 3 (off). Any other second byte sets `seq_err` and leaves `rb_mode` unchanged.
- R8: E0h takes a 16-bit count low byte first, then high byte, and gives `load_stb` with `op_count`. 0Ch takes a count the same way and gives `pbwrite_stb` with `op_count`, plus `op_addr` and `op_block` from the final cycle. In x8 mode (`wide_mode`=0), `bus_addr[0]` of the 0Ch first count cycle equal to 1 means that this cycle carries the high byte.
- R9: In x8 mode, FBh starts a two-byte write. `bus_addr[0]` of the first data cycle selects whether that byte is low (0) or high (1). The next cycle carries the other byte and the write address, and `twobyte_stb` gives `op_data` and `op_addr`. In x16 mode, FBh is ignored.
- R10: F0h gives `sleep_stb` and 80h gives `abort_stb`. A write of 80h in any intermediate cycle also gives `abort_stb` and returns to idle. An unknown opcode, and 71h, 72h and 75h, leave the sequencer idle with no strobe. 74h consumes exactly one following write as page-buffer data.
- R11: While `pwr_n` is low, `deep_pd` is 1 from the next clock edge, any partial command is discarded and bus writes are ignored.
- R12: Every strobe is one clock wide and at most one strobe is high at a time. The operands keep their values from one strobe to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Low: deep power-down, writes ignored |
| wp_n | input | 1 | Low: lock bits are enforced |
| wr_en | input | 1 | One-clock pulse per bus write cycle |
| bus_addr | input | 20 | Bus address; top 4 bits give the block |
| bus_data | input | 8 | Command or data byte |
| wide_mode | input | 1 | 1 = x16 bus, 0 = x8 bus |
| erase_stb | output | 1 | Block erase request |
| erase_all_stb | output | 1 | Erase of all unlocked blocks |
| lock_stb | output | 1 | Block lock request |
| load_stb | output | 1 | Sequential page-buffer load request |
| pbwrite_stb | output | 1 | Page buffer to flash write request |
| twobyte_stb | output | 1 | Two-byte write request |
| upload_stb | output | 1 | Status or device-information upload |
| sleep_stb | output | 1 | Sleep request |
| abort_stb | output | 1 | Abort request |
| op_block | output | 4 | Latched block index |
| op_addr | output | 20 | Latched write address |
| op_count | output | 16 | Latched count |
| op_data | output | 16 | Latched two-byte write data |
| op_mask | output | 16 | Blocks allowed in erase-all |
| op_info | output | 1 | Upload kind: 0 status, 1 device info |
| rb_mode | output | 2 | Ready/busy output mode |
| deep_pd | output | 1 | Deep power-down active |
| seq_err | output | 1 | Sticky command-sequence error |
| prot_err | output | 1 | Sticky protection error |

## Verification
Every strobe, operand, error flag and `rb_mode` update is registered on the clock edge that samples the final write of its command, so it is due one edge after that write. `deep_pd` follows `pwr_n` by one edge. A new lock bit takes effect one edge after `lock_stb`. The bench drives each write on a falling edge for one clock and samples on the next falling edge, which lies between the edge that produces a result and the edge that clears a strobe. It then waits one more clock to confirm that the strobe has dropped and that the operands have not changed.

// File: rtl/fcs_pkg.sv
// Shared constants for the flash command sequencer: opcodes, sequencer
// states, strobe indices and ready/busy mode encodings.
package fcs_pkg;

    localparam logic [7:0] OPC_ERASE   = 8'h20;
    localparam logic [7:0] OPC_LOCK    = 8'h77;
    localparam logic [7:0] OPC_ERALL   = 8'hA7;
    localparam logic [7:0] OPC_UPSTAT  = 8'h97;
    localparam logic [7:0] OPC_UPINFO  = 8'h99;
    localparam logic [7:0] OPC_RBMODE  = 8'h96;
    localparam logic [7:0] OPC_LOAD    = 8'hE0;
    localparam logic [7:0] OPC_PBWRITE = 8'h0C;
    localparam logic [7:0] OPC_TWOBYTE = 8'hFB;
    localparam logic [7:0] OPC_PBONE   = 8'h74;
    localparam logic [7:0] OPC_SLEEP   = 8'hF0;
    localparam logic [7:0] OPC_ABORT   = 8'h80;
    localparam logic [7:0] OPC_CLEAR   = 8'h50;
    localparam logic [7:0] OPC_CONFIRM = 8'hD0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONF,
        ST_MODE,
        ST_PART1,
        ST_PART2,
        ST_PBDATA
    } seq_state_t;

    localparam int SI_ERASE   = 0;
    localparam int SI_ERALL   = 1;
    localparam int SI_LOCK    = 2;
    localparam int SI_LOAD    = 3;
    localparam int SI_PBWRITE = 4;
    localparam int SI_TWOBYTE = 5;
    localparam int SI_UPLOAD  = 6;
    localparam int SI_SLEEP   = 7;
    localparam int SI_ABORT   = 8;
    localparam int NUM_STB    = 9;

    localparam logic [1:0] RB_LEVEL    = 2'd0;
    localparam logic [1:0] RB_PULSE_WR = 2'd1;
    localparam logic [1:0] RB_PULSE_ER = 2'd2;
    localparam logic [1:0] RB_OFF      = 2'd3;

endpackage

// File: rtl/fcs_lock_bank.sv
// One lock bit per block. A bit is set by a one-clock set request and is
// cleared only by reset. Assumes set_idx is valid whenever set_en is high.
module fcs_lock_bank #(
    parameter int BLK_W = 4,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_idx,
    output logic [NBLK-1:0]  lock_vec
);

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        // Hold the lock bit of block i; set on a matching request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_vec[i] <= 1'b0;
            else if (set_en && set_idx == BLK_W'(i))
                lock_vec[i] <= 1'b1;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_vec) & ~lock_vec) == '0);  // R3

    AST_LOCK_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vec != $past(lock_vec)) |-> $past(set_en));  // R3

endmodule

// File: rtl/fcs_cmd_fsm.sv
// Command sequencer core. It tracks the bus cycle within each command,
// checks confirm bytes, assembles counts and data bytes, applies block
// protection and registers one-clock strobes with their operands.
// Assumes wr_en is high for exactly one clock per bus write cycle.
module fcs_cmd_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              wp_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              wide_mode,
    input  logic [NBLK-1:0]   lock_vec,
    output logic [NUM_STB-1:0] stb,
    output logic [BLK_W-1:0]  op_block,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_count,
    output logic [15:0]       op_data,
    output logic [NBLK-1:0]   op_mask,
    output logic              op_info,
    output logic [1:0]        rb_mode,
    output logic              deep_pd,
    output logic              seq_err,
    output logic              prot_err
);

    seq_state_t       state;
    logic [7:0]       pend;
    logic [7:0]       hold;
    logic             swap;
    logic [BLK_W-1:0] blk;
    logic             prot_on;
    logic             locked_here;
    logic [15:0]      word;

    // Decode the target block and whether it is currently protected.
    always_comb begin
        blk         = bus_addr[ADDR_W-1 -: BLK_W];
        prot_on     = !wp_n;
        locked_here = prot_on && lock_vec[blk];
        word        = swap ? {hold, bus_data} : {bus_data, hold};
    end

    // Advance the command sequence and register strobes, operands and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= '0;
            hold     <= '0;
            swap     <= 1'b0;
            stb      <= '0;
            op_block <= '0;
            op_addr  <= '0;
            op_count <= '0;
            op_data  <= '0;
            op_mask  <= '0;
            op_info  <= 1'b0;
            rb_mode  <= RB_LEVEL;
            deep_pd  <= 1'b0;
            seq_err  <= 1'b0;
            prot_err <= 1'b0;
        end else begin
            stb     <= '0;
            deep_pd <= !pwr_n;
            if (!pwr_n) begin
                state <= ST_IDLE;
            end else if (wr_en && state != ST_IDLE && bus_data == OPC_ABORT) begin
                stb[SI_ABORT] <= 1'b1;
                state         <= ST_IDLE;
            end else if (wr_en) begin
                case (state)
                    ST_IDLE: begin
                        case (bus_data)
                            OPC_ERASE, OPC_LOCK, OPC_ERALL, OPC_UPSTAT, OPC_UPINFO: begin
                                pend  <= bus_data;
                                state <= ST_CONF;
                            end
                            OPC_RBMODE: state <= ST_MODE;
                            OPC_LOAD, OPC_PBWRITE: begin
                                pend  <= bus_data;
                                state <= ST_PART1;
                            end
                            OPC_TWOBYTE: begin
                                if (!wide_mode) begin
                                    pend  <= bus_data;
                                    state <= ST_PART1;
                                end
                            end
                            OPC_PBONE: state <= ST_PBDATA;
                            OPC_SLEEP: stb[SI_SLEEP] <= 1'b1;
                            OPC_ABORT: stb[SI_ABORT] <= 1'b1;
                            OPC_CLEAR: begin
                                seq_err  <= 1'b0;
                                prot_err <= 1'b0;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                    ST_CONF: begin
                        state <= ST_IDLE;
                        if (bus_data != OPC_CONFIRM) begin
                            seq_err <= 1'b1;
                        end else begin
                            case (pend)
                                OPC_ERASE: begin
                                    if (locked_here) begin
                                        prot_err <= 1'b1;
                                    end else begin
                                        stb[SI_ERASE] <= 1'b1;
                                        op_block      <= blk;
                                    end
                                end
                                OPC_LOCK: begin
                                    stb[SI_LOCK] <= 1'b1;
                                    op_block     <= blk;
                                end
                                OPC_ERALL: begin
                                    stb[SI_ERALL] <= 1'b1;
                                    op_mask       <= prot_on ? ~lock_vec : '1;
                                end
                                default: begin
                                    stb[SI_UPLOAD] <= 1'b1;
                                    op_info        <= (pend == OPC_UPINFO);
                                end
                            endcase
                        end
                    end
                    ST_MODE: begin
                        state <= ST_IDLE;
                        case (bus_data)
                            8'h01:   rb_mode <= RB_LEVEL;
                            8'h02:   rb_mode <= RB_PULSE_WR;
                            8'h03:   rb_mode <= RB_PULSE_ER;
                            8'h04:   rb_mode <= RB_OFF;
                            default: seq_err <= 1'b1;
                        endcase
                    end
                    ST_PART1: begin
                        hold  <= bus_data;
                        swap  <= !wide_mode && pend != OPC_LOAD && bus_addr[0];
                        state <= ST_PART2;
                    end
                    ST_PART2: begin
                        state <= ST_IDLE;
                        if (pend == OPC_LOAD) begin
                            stb[SI_LOAD] <= 1'b1;
                            op_count     <= word;
                        end else if (locked_here) begin
                            prot_err <= 1'b1;
                        end else if (pend == OPC_PBWRITE) begin
                            stb[SI_PBWRITE] <= 1'b1;
                            op_count        <= word;
                            op_addr         <= bus_addr;
                            op_block        <= blk;
                        end else begin
                            stb[SI_TWOBYTE] <= 1'b1;
                            op_data         <= word;
                            op_addr         <= bus_addr;
                            op_block        <= blk;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));  // R12

    AST_STB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb) |-> $past(wr_en));  // R12

    AST_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stb) |-> $stable({op_block, op_addr, op_count, op_data, op_mask, op_info}));  // R12

    AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        deep_pd |-> (stb == '0));  // R11

    AST_SEQERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(wr_en));  // R6

    AST_MODE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rb_mode) |-> $past(wr_en));  // R7

endmodule

// File: rtl/flash_cmd_seq.sv
// Top level of the flash command sequencer. It connects the sequencing core
// to the per-block lock bank and brings the strobes out as separate ports.
// Assumes the bus interface has already reduced each write to a one-clock pulse.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              wp_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              wide_mode,
    output logic              erase_stb,
    output logic              erase_all_stb,
    output logic              lock_stb,
    output logic              load_stb,
    output logic              pbwrite_stb,
    output logic              twobyte_stb,
    output logic              upload_stb,
    output logic              sleep_stb,
    output logic              abort_stb,
    output logic [BLK_W-1:0]  op_block,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_count,
    output logic [15:0]       op_data,
    output logic [NBLK-1:0]   op_mask,
    output logic              op_info,
    output logic [1:0]        rb_mode,
    output logic              deep_pd,
    output logic              seq_err,
    output logic              prot_err
);

    logic [NUM_STB-1:0] stb;
    logic [NBLK-1:0]    lock_vec;

    fcs_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_n     (pwr_n),
        .wp_n      (wp_n),
        .wr_en     (wr_en),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .wide_mode (wide_mode),
        .lock_vec  (lock_vec),
        .stb       (stb),
        .op_block  (op_block),
        .op_addr   (op_addr),
        .op_count  (op_count),
        .op_data   (op_data),
        .op_mask   (op_mask),
        .op_info   (op_info),
        .rb_mode   (rb_mode),
        .deep_pd   (deep_pd),
        .seq_err   (seq_err),
        .prot_err  (prot_err)
    );

    fcs_lock_bank #(.BLK_W(BLK_W)) locks_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (stb[SI_LOCK]),
        .set_idx  (op_block),
        .lock_vec (lock_vec)
    );

    // Split the strobe vector into named ports.
    always_comb begin
        erase_stb     = stb[SI_ERASE];
        erase_all_stb = stb[SI_ERALL];
        lock_stb      = stb[SI_LOCK];
        load_stb      = stb[SI_LOAD];
        pbwrite_stb   = stb[SI_PBWRITE];
        twobyte_stb   = stb[SI_TWOBYTE];
        upload_stb    = stb[SI_UPLOAD];
        sleep_stb     = stb[SI_SLEEP];
        abort_stb     = stb[SI_ABORT];
    end

endmodule

// File: tb/flash_cmd_seq_tb.sv
// Directed bench for the flash command sequencer: one task per scenario.
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_n = 1'b1;
    logic        wp_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        wide_mode = 1'b0;
    logic        erase_stb, erase_all_stb, lock_stb, load_stb, pbwrite_stb;
    logic        twobyte_stb, upload_stb, sleep_stb, abort_stb;
    logic [3:0]  op_block;
    logic [19:0] op_addr;
    logic [15:0] op_count, op_data, op_mask;
    logic        op_info;
    logic [1:0]  rb_mode;
    logic        deep_pd, seq_err, prot_err;
    logic [8:0]  all_stb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .wp_n(wp_n), .wr_en(wr_en),
        .bus_addr(bus_addr), .bus_data(bus_data), .wide_mode(wide_mode),
        .erase_stb(erase_stb), .erase_all_stb(erase_all_stb), .lock_stb(lock_stb),
        .load_stb(load_stb), .pbwrite_stb(pbwrite_stb), .twobyte_stb(twobyte_stb),
        .upload_stb(upload_stb), .sleep_stb(sleep_stb), .abort_stb(abort_stb),
        .op_block(op_block), .op_addr(op_addr), .op_count(op_count),
        .op_data(op_data), .op_mask(op_mask), .op_info(op_info),
        .rb_mode(rb_mode), .deep_pd(deep_pd), .seq_err(seq_err), .prot_err(prot_err)
    );

    assign all_stb = {abort_stb, sleep_stb, upload_stb, twobyte_stb, pbwrite_stb,
                      load_stb, lock_stb, erase_all_stb, erase_stb};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write cycle; returns on the falling edge after it was sampled.
    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle1();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle1();
        chk("R1 strobes", 32'(all_stb), 0);
        chk("R1 seq_err", 32'(seq_err), 0);
        chk("R1 prot_err", 32'(prot_err), 0);
        chk("R1 rb_mode", 32'(rb_mode), 0);
        chk("R1 deep_pd", 32'(deep_pd), 0);
    endtask

    task automatic t_erase();
        wr(20'h0, 8'h20); wr(20'h5_1234, 8'hD0);
        chk("R2 erase strobe", 32'(all_stb), 32'h001);
        chk("R2 erase block", 32'(op_block), 5);
        idle1();
        chk("R12 strobe one wide", 32'(all_stb), 0);
        wr(20'h0, 8'hF0);
        chk("R10 sleep strobe", 32'(all_stb), 32'h080);
        chk("R12 operand kept", 32'(op_block), 5);
    endtask

    task automatic t_lock_protect();
        wp_n = 1'b0;
        wr(20'h0, 8'h77); wr(20'h3_0000, 8'hD0);
        chk("R3 lock strobe", 32'(all_stb), 32'h004);
        chk("R3 lock block", 32'(op_block), 3);
        wr(20'h0, 8'h20); wr(20'h3_0040, 8'hD0);
        chk("R4 locked erase refused", 32'(all_stb), 0);
        chk("R4 prot_err set", 32'(prot_err), 1);
        wr(20'h0, 8'h50);
        chk("R6 clear prot_err", 32'(prot_err), 0);
        wr(20'h0, 8'h0C); wr(20'h0, 8'h10); wr(20'h3_0100, 8'h00);
        chk("R4 locked pbwrite refused", 32'(all_stb), 0);
        chk("R4 prot_err on pbwrite", 32'(prot_err), 1);
        wr(20'h0, 8'h50);
        wp_n = 1'b1;
        wr(20'h0, 8'h20); wr(20'h3_0040, 8'hD0);
        chk("R4 unprotected erase", 32'(erase_stb), 1);
        chk("R4 unprotected block", 32'(op_block), 3);
        chk("R4 no prot_err", 32'(prot_err), 0);
    endtask

    task automatic t_erase_all();
        wp_n = 1'b0;
        wr(20'h0, 8'hA7); wr(20'h0, 8'hD0);
        chk("R5 erase-all strobe", 32'(erase_all_stb), 1);
        chk("R5 mask protected", 32'(op_mask), 32'hFFF7);
        wp_n = 1'b1;
        wr(20'h0, 8'hA7); wr(20'h0, 8'hD0);
        chk("R5 mask open", 32'(op_mask), 32'hFFFF);
        wp_n = 1'b0;
        wr(20'h0, 8'h97); wr(20'h0, 8'hD0);
        chk("R5 status upload", 32'(all_stb), 32'h040);
        chk("R5 status info", 32'(op_info), 0);
        wr(20'h0, 8'h99); wr(20'h0, 8'hD0);
        chk("R5 device upload", 32'(upload_stb), 1);
        chk("R5 device info", 32'(op_info), 1);
    endtask

    task automatic t_confirm();
        wr(20'h0, 8'h20); wr(20'h1_0000, 8'h55);
        chk("R6 bad confirm no strobe", 32'(all_stb), 0);
        chk("R6 seq_err set", 32'(seq_err), 1);
        wr(20'h0, 8'h20); wr(20'h1_0000, 8'hD0);
        chk("R6 back to idle", 32'(erase_stb), 1);
        chk("R6 seq_err sticky", 32'(seq_err), 1);
        wr(20'h0, 8'h50);
        chk("R6 clear seq_err", 32'(seq_err), 0);
    endtask

    task automatic t_mode();
        wr(20'h0, 8'h96); wr(20'h0, 8'h02);
        chk("R7 pulse on write", 32'(rb_mode), 1);
        wr(20'h0, 8'h96); wr(20'h0, 8'h04);
        chk("R7 disabled", 32'(rb_mode), 3);
        wr(20'h0, 8'h96); wr(20'h0, 8'h07);
        chk("R7 bad mode kept", 32'(rb_mode), 3);
        chk("R7 bad mode seq_err", 32'(seq_err), 1);
        wr(20'h0, 8'h50);
        wr(20'h0, 8'h96); wr(20'h0, 8'h03);
        chk("R7 pulse on erase", 32'(rb_mode), 2);
        wr(20'h0, 8'h96); wr(20'h0, 8'h01);
        chk("R7 level", 32'(rb_mode), 0);
    endtask

    task automatic t_counts();
        wide_mode = 1'b0;
        wr(20'h0, 8'hE0); wr(20'h0, 8'h34); wr(20'h0, 8'h12);
        chk("R8 x8 load strobe", 32'(all_stb), 32'h008);
        chk("R8 x8 load count", 32'(op_count), 32'h1234);
        wr(20'h0, 8'h0C); wr(20'h0_0001, 8'h56); wr(20'h2_0010, 8'h78);
        chk("R8 x8 pbwrite strobe", 32'(pbwrite_stb), 1);
        chk("R8 x8 swapped count", 32'(op_count), 32'h5678);
        chk("R8 x8 pbwrite addr", 32'(op_addr), 32'h2_0010);
        wide_mode = 1'b1;
        wr(20'h0, 8'h0C); wr(20'h0_0001, 8'h9A); wr(20'h4_0200, 8'hBC);
        chk("R8 x16 pbwrite count", 32'(op_count), 32'hBC9A);
        chk("R8 x16 pbwrite block", 32'(op_block), 4);
        wide_mode = 1'b0;
    endtask

    task automatic t_twobyte();
        wide_mode = 1'b0;
        wr(20'h0, 8'hFB); wr(20'h0_0000, 8'hCD); wr(20'h6_0020, 8'hAB);
        chk("R9 twobyte strobe", 32'(all_stb), 32'h020);
        chk("R9 twobyte data low first", 32'(op_data), 32'hABCD);
        chk("R9 twobyte addr", 32'(op_addr), 32'h6_0020);
        wr(20'h0, 8'hFB); wr(20'h0_0001, 8'h11); wr(20'h6_0022, 8'h22);
        chk("R9 twobyte data high first", 32'(op_data), 32'h1122);
        wide_mode = 1'b1;
        wr(20'h0, 8'hFB); wr(20'h0, 8'h20); wr(20'h7_0000, 8'hD0);
        chk("R9 FBh ignored in x16", 32'(erase_stb), 1);
        chk("R9 x16 erase block", 32'(op_block), 7);
        wide_mode = 1'b0;
    endtask

    task automatic t_single();
        wr(20'h0, 8'h80);
        chk("R10 abort strobe", 32'(all_stb), 32'h100);
        wr(20'h0, 8'h20); wr(20'h0, 8'h80);
        chk("R10 abort mid-command", 32'(abort_stb), 1);
        wr(20'h0, 8'hD0);
        chk("R10 idle after abort", 32'(all_stb), 0);
        chk("R10 no seq_err after abort", 32'(seq_err), 0);
        wr(20'h0, 8'h33); wr(20'h0, 8'h71); wr(20'h0, 8'h72); wr(20'h0, 8'h75);
        chk("R10 unknown ignored", 32'(all_stb), 0);
        wr(20'h0, 8'h20); wr(20'h8_0000, 8'hD0);
        chk("R10 still idle", 32'(erase_stb), 1);
        wr(20'h0, 8'h74); wr(20'h0, 8'h20); wr(20'h9_0000, 8'hD0);
        chk("R10 74h consumes one write", 32'(all_stb), 0);
        chk("R10 74h no seq_err", 32'(seq_err), 0);
    endtask

    task automatic t_pd();
        wr(20'h0, 8'h20);
        @(negedge clk); pwr_n = 1'b0;
        @(negedge clk);
        chk("R11 deep_pd set", 32'(deep_pd), 1);
        wr(20'h0, 8'hF0);
        chk("R11 write ignored", 32'(all_stb), 0);
        @(negedge clk); pwr_n = 1'b1;
        @(negedge clk);
        chk("R11 deep_pd clear", 32'(deep_pd), 0);
        wr(20'hA_0000, 8'hD0);
        chk("R11 partial discarded", 32'(all_stb), 0);
        chk("R11 no seq_err", 32'(seq_err), 0);
    endtask

    initial begin
        t_reset();
        t_erase();
        t_lock_protect();
        t_erase_all();
        t_confirm();
        t_mode();
        t_counts();
        t_twobyte();
        t_single();
        t_pd();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule